// File: doc/BRIEF.md
# Reorder Buffer with Tag Wake-up and Kill

This block is the in-order retirement window of an out-of-order core. Decode writes instructions into it at the tail. Each entry holds its instruction word, a destination register, two source operands and a result. Each operand is either a value or the index of the entry that will produce it. Each entry is in exactly one of five states: empty, waiting, issued, killed or done. Every cycle the buffer offers the oldest waiting entry whose two operands are both present to an execution unit. When a unit returns a result, the buffer stores it in the producing entry and copies it into every operand that names that entry. The oldest entry is then handed to the register file once it is done.

When a branch is found to be mispredicted, the core names the branch entry and every younger occupied entry becomes killed at once. A parameter selects the recovery style. In rewind mode the tail jumps back to the entry just after the branch, so the killed entries are reused by later inserts. In drain mode the tail stays where it is and killed entries leave at the head, one per cycle, without writing the register file. An insert that meets a writeback of its own producer in the same cycle captures the value, not the tag.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: `ins_ready` is 1, `ins_tag` is 0, and `disp_valid` and `cm_valid` are 0.
- R2: An insert is accepted when `ins_valid` and `ins_ready` are both 1. It lands in entry `ins_tag`, and `ins_tag` then advances by one modulo DEPTH. `ins_ready` is 0 while DEPTH entries are occupied.
- R3: `disp_valid` is 1 when some waiting entry has both operands present. `disp_tag` names the oldest such entry counted from the head, wrapping past the last index. `disp_take` moves that entry to issued, and an entry inserted with two values is offered in the cycle after the insert.
- R4: A writeback (`wb_valid`, `wb_tag`, `wb_data`) to an issued entry stores the result and makes it done. It also fills every waiting operand that holds tag `wb_tag`, and a consumer filled this way is offered in the next cycle.
- R5: An operand given as a tag (`ins_x_val` = 0, tag in the low bits of `ins_x_data`) and inserted in the same cycle as an accepted writeback to that tag is stored as the written-back value.
- R6: Entries leave strictly in insertion order. `cm_valid`, `cm_dest` and `cm_data` present the head entry while it is done, and the entry leaves at the next clock edge. A younger done entry is held until the head is done.
- R7: `br_kill` with `br_tag` naming an occupied entry kills every occupied entry younger than it. Killed entries are never offered for dispatch, never presented on the commit port, and ignore writebacks.
- R8: With REWIND = 1 (default), a kill sets `ins_tag` to `br_tag` + 1 modulo DEPTH in the following cycle.
- R9: With REWIND = 0, a kill leaves `ins_tag` unchanged. Killed entries that reach the head leave one per cycle with `cm_valid` at 0.
- R10: While `br_kill` is 1, `ins_ready` is 0 and an insert presented in that cycle is dropped.
- R11: A kill whose `br_tag` does not name an occupied entry has no effect on any entry or pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Decode offers an instruction |
| ins_ready | output | 1 | Buffer accepts an instruction this cycle |
| ins_instr | input | IW | Instruction word |
| ins_dest | input | RW | Destination register |
| ins_a_val | input | 1 | Operand A is a value (1) or a producer tag (0) |
| ins_a_data | input | DW | Operand A value, or tag in the low bits |
| ins_b_val | input | 1 | Operand B is a value (1) or a producer tag (0) |
| ins_b_data | input | DW | Operand B value, or tag in the low bits |
| ins_tag | output | log2(DEPTH) | Entry the next insert lands in |
| disp_valid | output | 1 | A ready entry is offered |
| disp_take | input | 1 | Execution unit accepts the offered entry |
| disp_tag | output | log2(DEPTH) | Offered entry index |
| disp_instr | output | IW | Offered instruction word |
| disp_a | output | DW | Offered operand A |
| disp_b | output | DW | Offered operand B |
| wb_valid | input | 1 | Result returned |
| wb_tag | input | log2(DEPTH) | Entry producing the result |
| wb_data | input | DW | Result value |
| cm_valid | output | 1 | Head entry writes the register file |
| cm_dest | output | RW | Destination register of the head |
| cm_data | output | DW | Result of the head |
| br_kill | input | 1 | Misprediction recovery request |
| br_tag | input | log2(DEPTH) | Entry holding the mispredicted branch |

## Verification
An accepted insert shows up one clock edge later: `ins_tag` advances and, if both operands were values, `disp_valid` names the entry. A writeback makes the entry done and fills its consumers at that same edge, so `cm_valid` and the consumer's dispatch offer are both visible before the next edge, and the entry leaves at that next edge. A kill changes `ins_tag` one edge after `br_kill`, and in drain mode each killed entry at the head takes one further edge. The bench drives every input just after a falling edge and reads the outputs at the following falling edge, so each reading falls between the edge that produced it and the edge that would change it. Two instances, one per recovery mode, take the same stimulus and are checked against their own expected values.

// File: rtl/rob_pkg.sv
package rob_pkg;

   // Life of one buffer entry.
   typedef enum logic [2:0] {
      ST_EMPTY  = 3'd0,
      ST_WAIT   = 3'd1,
      ST_ISSUED = 3'd2,
      ST_KILLED = 3'd3,
      ST_DONE   = 3'd4
   } rob_state_e;

endpackage

// File: rtl/rob_ptr.sv
// Head and tail pointers with a wrap bit; occupancy is their difference.
module rob_ptr #(
   parameter int DEPTH  = 16,
   parameter bit REWIND = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic                       pop,
   input  logic                       flush,
   input  logic [$clog2(DEPTH)-1:0]   flush_age,
   output logic [$clog2(DEPTH)-1:0]   head,
   output logic [$clog2(DEPTH)-1:0]   tail,
   output logic [$clog2(DEPTH):0]     count
);
   localparam int PW = $clog2(DEPTH);

   logic [PW:0] head_q;
   logic [PW:0] tail_q;
   logic [PW:0] rew_tail;

   // Entry after the branch, measured from the current head.
   assign rew_tail = head_q + {1'b0, flush_age} + (PW+1)'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
      end else begin
         head_q <= head_q + (PW+1)'(pop);
         if (REWIND && flush) begin
            tail_q <= rew_tail;
         end else if (push) begin
            tail_q <= tail_q + (PW+1)'(1);
         end
      end
   end

   assign head  = head_q[PW-1:0];
   assign tail  = tail_q[PW-1:0];
   assign count = tail_q - head_q;

endmodule

// File: rtl/rob_pick.sv
// Oldest-first selector: the lowest set request at or after base, wrapping.
module rob_pick #(
   parameter int DEPTH = 16
) (
   input  logic [DEPTH-1:0]           req,
   input  logic [$clog2(DEPTH)-1:0]   base,
   output logic                       found,
   output logic [$clog2(DEPTH)-1:0]   idx
);
   localparam int PW = $clog2(DEPTH);

   always_comb begin
      found = 1'b0;
      idx   = base;
      // Walk from the youngest offset down so the oldest hit is kept last.
      for (int k = DEPTH - 1; k >= 0; k--) begin
         if (req[base + PW'(k)]) begin
            found = 1'b1;
            idx   = base + PW'(k);
         end
      end
   end

endmodule

// File: rtl/rob_opnd.sv
// One source operand: holds a value, or a producer tag until wake-up.
module rob_opnd #(
   parameter int DW = 32,
   parameter int TW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld,
   input  logic          ld_val,
   input  logic [DW-1:0] ld_data,
   input  logic          watch,
   input  logic          wb_hit,
   input  logic [TW-1:0] wb_tag,
   input  logic [DW-1:0] wb_data,
   output logic          ok,
   output logic [DW-1:0] data
);
   logic ld_fwd;
   logic wake;

   // Producer finishing in the very cycle its consumer is written.
   assign ld_fwd = wb_hit && (ld_data[TW-1:0] == wb_tag);
   assign wake   = watch && !ok && wb_hit && (data[TW-1:0] == wb_tag);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ok   <= 1'b0;
         data <= '0;
      end else if (ld) begin
         if (ld_val) begin
            ok   <= 1'b1;
            data <= ld_data;
         end else if (ld_fwd) begin
            ok   <= 1'b1;
            data <= wb_data;
         end else begin
            ok   <= 1'b0;
            data <= ld_data;
         end
      end else if (wake) begin
         ok   <= 1'b1;
         data <= wb_data;
      end
   end

endmodule

// File: rtl/rob_slot.sv
// One buffer entry: state machine, payload, result and two operands.
module rob_slot
   import rob_pkg::*;
#(
   parameter int DW = 32,
   parameter int IW = 16,
   parameter int RW = 5,
   parameter int TW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld,
   input  logic [IW-1:0] ld_instr,
   input  logic [RW-1:0] ld_dest,
   input  logic          ld_a_val,
   input  logic [DW-1:0] ld_a_data,
   input  logic          ld_b_val,
   input  logic [DW-1:0] ld_b_data,
   input  logic          issue,
   input  logic          kill,
   input  logic          retire,
   input  logic          wb_mine,
   input  logic          wb_hit,
   input  logic [TW-1:0] wb_tag,
   input  logic [DW-1:0] wb_data,
   output rob_state_e    st,
   output logic          a_ok,
   output logic [DW-1:0] a_data,
   output logic          b_ok,
   output logic [DW-1:0] b_data,
   output logic [IW-1:0] instr,
   output logic [RW-1:0] dest,
   output logic [DW-1:0] result
);
   logic watch;
   logic finish;

   assign watch  = (st == ST_WAIT);
   assign finish = wb_mine && (st == ST_ISSUED);

   // Priority: fresh load, then kill, then retire, then completion, then issue.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= ST_EMPTY;
      end else if (ld) begin
         st <= ST_WAIT;
      end else if (kill) begin
         st <= ST_KILLED;
      end else if (retire) begin
         st <= ST_EMPTY;
      end else if (finish) begin
         st <= ST_DONE;
      end else if (issue && watch) begin
         st <= ST_ISSUED;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         instr  <= '0;
         dest   <= '0;
         result <= '0;
      end else if (ld) begin
         instr  <= ld_instr;
         dest   <= ld_dest;
         result <= '0;
      end else if (finish && !kill) begin
         result <= wb_data;
      end
   end

   rob_opnd #(.DW(DW), .TW(TW)) u_opa (
      .clk(clk), .rst_n(rst_n), .ld(ld), .ld_val(ld_a_val), .ld_data(ld_a_data),
      .watch(watch), .wb_hit(wb_hit), .wb_tag(wb_tag), .wb_data(wb_data),
      .ok(a_ok), .data(a_data)
   );

   rob_opnd #(.DW(DW), .TW(TW)) u_opb (
      .clk(clk), .rst_n(rst_n), .ld(ld), .ld_val(ld_b_val), .ld_data(ld_b_data),
      .watch(watch), .wb_hit(wb_hit), .wb_tag(wb_tag), .wb_data(wb_data),
      .ok(b_ok), .data(b_data)
   );

endmodule

// File: rtl/rob_core.sv
module rob_core
   import rob_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int DW     = 32,
   parameter int IW     = 16,
   parameter int RW     = 5,
   parameter bit REWIND = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ins_valid,
   output logic                       ins_ready,
   input  logic [IW-1:0]              ins_instr,
   input  logic [RW-1:0]              ins_dest,
   input  logic                       ins_a_val,
   input  logic [DW-1:0]              ins_a_data,
   input  logic                       ins_b_val,
   input  logic [DW-1:0]              ins_b_data,
   output logic [$clog2(DEPTH)-1:0]   ins_tag,
   output logic                       disp_valid,
   input  logic                       disp_take,
   output logic [$clog2(DEPTH)-1:0]   disp_tag,
   output logic [IW-1:0]              disp_instr,
   output logic [DW-1:0]              disp_a,
   output logic [DW-1:0]              disp_b,
   input  logic                       wb_valid,
   input  logic [$clog2(DEPTH)-1:0]   wb_tag,
   input  logic [DW-1:0]              wb_data,
   output logic                       cm_valid,
   output logic [RW-1:0]              cm_dest,
   output logic [DW-1:0]              cm_data,
   input  logic                       br_kill,
   input  logic [$clog2(DEPTH)-1:0]   br_tag
);
   localparam int PW = $clog2(DEPTH);
   localparam logic [PW:0] FULL_CNT = (PW+1)'(DEPTH);

   // Elaboration-time parameter checks.
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("rob_core: DEPTH must be a power of two, at least 2");
   end
   if (PW > DW) begin : g_bad_width
      $error("rob_core: a tag must fit in an operand");
   end

   rob_state_e [DEPTH-1:0] slot_st;
   logic [DEPTH-1:0]       a_ok, b_ok, req, kill_v, ld_v, iss_v, ret_v, wbm_v;
   logic [DW-1:0]          a_arr   [DEPTH];
   logic [DW-1:0]          b_arr   [DEPTH];
   logic [DW-1:0]          res_arr [DEPTH];
   logic [IW-1:0]          ins_arr [DEPTH];
   logic [RW-1:0]          dst_arr [DEPTH];

   logic [PW-1:0] head, tail;
   logic [PW:0]   count;
   logic [PW-1:0] br_age;
   logic          kill_ok, ins_fire, retire, wb_hit, issue_fire, occupied;
   rob_state_e    head_st;

   // Pointer state.
   rob_ptr #(.DEPTH(DEPTH), .REWIND(REWIND)) u_ptr (
      .clk(clk), .rst_n(rst_n), .push(ins_fire), .pop(retire),
      .flush(kill_ok), .flush_age(br_age),
      .head(head), .tail(tail), .count(count)
   );

   assign occupied  = (count != '0);
   assign ins_ready = (count != FULL_CNT) && !br_kill;
   assign ins_fire  = ins_valid && ins_ready;
   assign ins_tag   = tail;

   // Recovery is honoured only when the branch lies inside the window.
   assign br_age  = br_tag - head;
   assign kill_ok = br_kill && ({1'b0, br_age} < count);

   // Head retirement.
   assign head_st  = slot_st[head];
   assign retire   = occupied && (head_st == ST_DONE || head_st == ST_KILLED);
   assign cm_valid = occupied && (head_st == ST_DONE);
   assign cm_dest  = dst_arr[head];
   assign cm_data  = res_arr[head];

   // Results are accepted only by entries still in flight.
   assign wb_hit = wb_valid && (slot_st[wb_tag] == ST_ISSUED);

   // Dispatch selection.
   rob_pick #(.DEPTH(DEPTH)) u_pick (
      .req(req), .base(head), .found(disp_valid), .idx(disp_tag)
   );

   assign issue_fire = disp_valid && disp_take;
   assign disp_instr = ins_arr[disp_tag];
   assign disp_a     = a_arr[disp_tag];
   assign disp_b     = b_arr[disp_tag];

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic [PW-1:0] age;
      logic          in_win;

      assign age       = PW'(g) - head;
      assign in_win    = ({1'b0, age} < count);
      assign kill_v[g] = kill_ok && in_win && (age > br_age);
      assign ld_v[g]   = ins_fire && (tail == PW'(g));
      assign iss_v[g]  = issue_fire && (disp_tag == PW'(g));
      assign ret_v[g]  = retire && (head == PW'(g));
      assign wbm_v[g]  = wb_valid && (wb_tag == PW'(g));
      assign req[g]    = (slot_st[g] == ST_WAIT) && a_ok[g] && b_ok[g];

      rob_slot #(.DW(DW), .IW(IW), .RW(RW), .TW(PW)) u_slot (
         .clk(clk), .rst_n(rst_n),
         .ld(ld_v[g]), .ld_instr(ins_instr), .ld_dest(ins_dest),
         .ld_a_val(ins_a_val), .ld_a_data(ins_a_data),
         .ld_b_val(ins_b_val), .ld_b_data(ins_b_data),
         .issue(iss_v[g]), .kill(kill_v[g]), .retire(ret_v[g]),
         .wb_mine(wbm_v[g]), .wb_hit(wb_hit), .wb_tag(wb_tag), .wb_data(wb_data),
         .st(slot_st[g]),
         .a_ok(a_ok[g]), .a_data(a_arr[g]),
         .b_ok(b_ok[g]), .b_data(b_arr[g]),
         .instr(ins_arr[g]), .dest(dst_arr[g]), .result(res_arr[g])
      );
   end

endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk
   import rob_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter bit REWIND = 1'b1
) (
   input logic                       clk,
   input logic                       rst_n,
   input rob_state_e [DEPTH-1:0]     slot_st,
   input logic [$clog2(DEPTH)-1:0]   head,
   input logic [$clog2(DEPTH):0]     count,
   input logic                       ins_ready,
   input logic [$clog2(DEPTH)-1:0]   ins_tag,
   input logic                       br_kill,
   input logic [$clog2(DEPTH)-1:0]   br_tag,
   input logic                       kill_ok,
   input logic                       disp_valid,
   input logic                       disp_take,
   input logic [$clog2(DEPTH)-1:0]   disp_tag,
   input logic                       wb_valid,
   input logic [$clog2(DEPTH)-1:0]   wb_tag,
   input logic                       cm_valid
);
   localparam int PW = $clog2(DEPTH);

   p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      count <= (PW+1)'(DEPTH));

   p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (count == (PW+1)'(DEPTH)) |-> !ins_ready);

   p_pick_waiting_r3: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid |-> (slot_st[disp_tag] == ST_WAIT));

   p_issue_marks_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && disp_take && !br_kill) |=> (slot_st[$past(disp_tag)] == ST_ISSUED));

   p_wb_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && slot_st[wb_tag] == ST_ISSUED && !br_kill)
      |=> (slot_st[$past(wb_tag)] == ST_DONE));

   p_commit_frees_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cm_valid |=> (slot_st[$past(head)] != ST_DONE));

   p_killed_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_st[head] == ST_KILLED) |-> !cm_valid);

   p_kill_blocks_ins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      br_kill |-> !ins_ready);

   if (REWIND) begin : g_rewind
      p_tail_rewind_r8: assert property (@(posedge clk) disable iff (!rst_n)
         kill_ok |=> (ins_tag == PW'($past(br_tag) + 1'b1)));
   end else begin : g_drain
      p_tail_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
         kill_ok |=> (ins_tag == $past(ins_tag)));
   end

   p_stray_kill_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (br_kill && !kill_ok) |=> (ins_tag == $past(ins_tag)));

endmodule

bind rob_core rob_core_chk #(.DEPTH(DEPTH), .REWIND(REWIND)) u_chk (
   .clk(clk), .rst_n(rst_n), .slot_st(slot_st), .head(head), .count(count),
   .ins_ready(ins_ready), .ins_tag(ins_tag), .br_kill(br_kill), .br_tag(br_tag),
   .kill_ok(kill_ok), .disp_valid(disp_valid), .disp_take(disp_take),
   .disp_tag(disp_tag), .wb_valid(wb_valid), .wb_tag(wb_tag), .cm_valid(cm_valid)
);

// File: tb/rob_core_tb.sv
`timescale 1ns/1ps
module rob_core_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ins_valid = 1'b0;
   logic [15:0] ins_instr = '0;
   logic [4:0]  ins_dest = '0;
   logic        ins_a_val = 1'b0;
   logic [31:0] ins_a_data = '0;
   logic        ins_b_val = 1'b0;
   logic [31:0] ins_b_data = '0;
   logic        disp_take = 1'b0;
   logic        wb_valid = 1'b0;
   logic [3:0]  wb_tag = '0;
   logic [31:0] wb_data = '0;
   logic        br_kill = 1'b0;
   logic [3:0]  br_tag = '0;

   logic        r_rdy, d_rdy, r_dv, d_dv, r_cv, d_cv;
   logic [3:0]  r_itag, d_itag, r_dtag, d_dtag;
   logic [15:0] r_dins, d_dins;
   logic [31:0] r_da, d_da, r_db, d_db, r_cd, d_cd;
   logic [4:0]  r_cdst, d_cdst;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   rob_core #(.DEPTH(16), .DW(32), .IW(16), .RW(5), .REWIND(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(r_rdy),
      .ins_instr(ins_instr), .ins_dest(ins_dest),
      .ins_a_val(ins_a_val), .ins_a_data(ins_a_data),
      .ins_b_val(ins_b_val), .ins_b_data(ins_b_data), .ins_tag(r_itag),
      .disp_valid(r_dv), .disp_take(disp_take), .disp_tag(r_dtag),
      .disp_instr(r_dins), .disp_a(r_da), .disp_b(r_db),
      .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
      .cm_valid(r_cv), .cm_dest(r_cdst), .cm_data(r_cd),
      .br_kill(br_kill), .br_tag(br_tag)
   );

   rob_core #(.DEPTH(16), .DW(32), .IW(16), .RW(5), .REWIND(1'b0)) u_drain (
      .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(d_rdy),
      .ins_instr(ins_instr), .ins_dest(ins_dest),
      .ins_a_val(ins_a_val), .ins_a_data(ins_a_data),
      .ins_b_val(ins_b_val), .ins_b_data(ins_b_data), .ins_tag(d_itag),
      .disp_valid(d_dv), .disp_take(disp_take), .disp_tag(d_dtag),
      .disp_instr(d_dins), .disp_a(d_da), .disp_b(d_db),
      .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
      .cm_valid(d_cv), .cm_dest(d_cdst), .cm_data(d_cd),
      .br_kill(br_kill), .br_tag(br_tag)
   );

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      ins_valid = 1'b0; disp_take = 1'b0; wb_valid = 1'b0; br_kill = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic ins(input [15:0] ii, input [4:0] dd, input av, input [31:0] ad,
                      input bv, input [31:0] bd);
      ins_valid = 1'b1; ins_instr = ii; ins_dest = dd;
      ins_a_val = av; ins_a_data = ad; ins_b_val = bv; ins_b_data = bd;
      cyc();
      ins_valid = 1'b0;
   endtask

   task automatic take();
      disp_take = 1'b1;
      cyc();
      disp_take = 1'b0;
   endtask

   task automatic wb(input [3:0] t, input [31:0] d);
      wb_valid = 1'b1; wb_tag = t; wb_data = d;
      cyc();
      wb_valid = 1'b0;
   endtask

   task automatic kill(input [3:0] t);
      br_kill = 1'b1; br_tag = t;
      #1;
      chk("R10 kill blocks insert (rewind)", 32'(r_rdy), 32'd0);
      chk("R10 kill blocks insert (drain)", 32'(d_rdy), 32'd0);
      cyc();
      br_kill = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 ins_ready", 32'(r_rdy), 32'd1);
      chk("R1 ins_tag", 32'(r_itag), 32'd0);
      chk("R1 disp_valid", 32'(r_dv), 32'd0);
      chk("R1 cm_valid", 32'(d_cv), 32'd0);
   endtask

   task automatic t_basic();
      do_reset();
      ins(16'h1111, 5'd3, 1'b1, 32'hA, 1'b1, 32'hB);
      chk("R2 tag advances", 32'(r_itag), 32'd1);
      chk("R3 offered", 32'(r_dv), 32'd1);
      chk("R3 tag", 32'(r_dtag), 32'd0);
      chk("R3 instr", 32'(r_dins), 32'h1111);
      chk("R3 opa", r_da, 32'hA);
      chk("R3 opb", r_db, 32'hB);
      take();
      chk("R3 issued not offered", 32'(r_dv), 32'd0);
      chk("R6 not done yet", 32'(r_cv), 32'd0);
      wb(4'd0, 32'hC0DE);
      chk("R6 commit valid", 32'(r_cv), 32'd1);
      chk("R6 commit dest", 32'(r_cdst), 32'd3);
      chk("R6 commit data", r_cd, 32'hC0DE);
      cyc();
      chk("R6 retired", 32'(r_cv), 32'd0);
   endtask

   task automatic t_wakeup();
      do_reset();
      ins(16'h2000, 5'd1, 1'b1, 32'd1, 1'b1, 32'd2);
      ins(16'h2001, 5'd2, 1'b0, 32'd0, 1'b1, 32'd7);
      chk("R4 producer offered", 32'(r_dtag), 32'd0);
      take();
      chk("R4 consumer waits", 32'(r_dv), 32'd0);
      wb(4'd0, 32'd55);
      chk("R4 consumer woken", 32'(r_dv), 32'd1);
      chk("R4 consumer tag", 32'(r_dtag), 32'd1);
      chk("R4 forwarded value", r_da, 32'd55);
      chk("R4 other operand", r_db, 32'd7);
   endtask

   task automatic t_collide();
      do_reset();
      ins(16'h3000, 5'd1, 1'b1, 32'd1, 1'b1, 32'd2);
      take();
      ins_valid = 1'b1; ins_instr = 16'h3001; ins_dest = 5'd2;
      ins_a_val = 1'b0; ins_a_data = 32'd0; ins_b_val = 1'b1; ins_b_data = 32'd9;
      wb_valid = 1'b1; wb_tag = 4'd0; wb_data = 32'd77;
      cyc();
      ins_valid = 1'b0; wb_valid = 1'b0;
      chk("R5 consumer ready", 32'(r_dv), 32'd1);
      chk("R5 consumer tag", 32'(r_dtag), 32'd1);
      chk("R5 value captured", r_da, 32'd77);
   endtask

   task automatic t_oldest();
      do_reset();
      for (int i = 0; i < 3; i++) ins(16'hA0 + 16'(i), 5'(i), 1'b1, 32'(i), 1'b1, 32'd0);
      chk("R3 oldest first", 32'(r_dtag), 32'd0);
      take();
      chk("R3 next oldest", 32'(r_dtag), 32'd1);
      chk("R3 next instr", 32'(r_dins), 32'hA1);
      take();
      chk("R3 third", 32'(r_dtag), 32'd2);
      take();
      chk("R3 none left", 32'(r_dv), 32'd0);
   endtask

   task automatic t_full();
      do_reset();
      for (int i = 0; i < 16; i++) ins(16'hF0 + 16'(i), 5'(i), 1'b1, 32'(i), 1'b1, 32'd0);
      chk("R2 full not ready", 32'(r_rdy), 32'd0);
      chk("R2 tag wraps", 32'(r_itag), 32'd0);
      ins(16'hEE, 5'd0, 1'b1, 32'd0, 1'b1, 32'd0);
      take();
      wb(4'd0, 32'd1);
      chk("R6 head commits", 32'(r_cv), 32'd1);
      cyc();
      chk("R2 ready after retire", 32'(r_rdy), 32'd1);
      chk("R2 tail at zero", 32'(r_itag), 32'd0);
      chk("R2 dropped insert absent", 32'(r_dins), 32'hF1);
      ins(16'hBB, 5'd0, 1'b1, 32'd0, 1'b1, 32'd0);
      chk("R3 oldest across wrap", 32'(r_dtag), 32'd1);
      chk("R2 full again", 32'(r_rdy), 32'd0);
   endtask

   task automatic t_order();
      do_reset();
      ins(16'h4000, 5'd1, 1'b1, 32'd0, 1'b1, 32'd0);
      ins(16'h4001, 5'd2, 1'b1, 32'd0, 1'b1, 32'd0);
      take();
      take();
      wb(4'd1, 32'h22);
      chk("R6 younger held", 32'(r_cv), 32'd0);
      wb(4'd0, 32'h11);
      chk("R6 first dest", 32'(r_cdst), 32'd1);
      chk("R6 first data", r_cd, 32'h11);
      cyc();
      chk("R6 second valid", 32'(r_cv), 32'd1);
      chk("R6 second data", r_cd, 32'h22);
      cyc();
      chk("R6 drained", 32'(r_cv), 32'd0);
   endtask

   task automatic t_kill();
      do_reset();
      for (int i = 0; i < 5; i++) ins(16'hB0 + 16'(i), 5'(i), 1'b1, 32'(i), 1'b1, 32'd0);
      kill(4'd1);
      chk("R8 tail rewound", 32'(r_itag), 32'd2);
      chk("R9 tail kept", 32'(d_itag), 32'd5);
      take();
      take();
      chk("R7 killed not offered (rewind)", 32'(r_dv), 32'd0);
      chk("R7 killed not offered (drain)", 32'(d_dv), 32'd0);
      wb(4'd0, 32'h10);
      chk("R6 branch-older commit", 32'(d_cdst), 32'd0);
      wb(4'd1, 32'h11);
      chk("R6 branch commit", 32'(d_cdst), 32'd1);
      for (int i = 0; i < 3; i++) begin
         cyc();
         chk("R9 killed retire silently", 32'(d_cv), 32'd0);
      end
      ins(16'hC5, 5'd9, 1'b1, 32'd0, 1'b1, 32'd0);
      chk("R8 reuse killed slot", 32'(r_dtag), 32'd2);
      chk("R9 next slot after kill", 32'(d_dtag), 32'd5);
      take();
      wb(4'd2, 32'h99);
      chk("R8 commit reused slot", 32'(r_cv), 32'd1);
      chk("R7 wb to killed ignored (drain)", 32'(d_cv), 32'd0);
      wb(4'd5, 32'h99);
      chk("R8 already retired", 32'(r_cv), 32'd0);
      chk("R9 head passed killed", 32'(d_cv), 32'd1);
      chk("R9 commit dest", 32'(d_cdst), 32'd9);
   endtask

   task automatic t_kill_wb();
      do_reset();
      ins(16'hD0, 5'd1, 1'b1, 32'd0, 1'b1, 32'd0);
      ins(16'hD1, 5'd2, 1'b1, 32'd0, 1'b1, 32'd0);
      take();
      take();
      kill(4'd0);
      wb(4'd1, 32'h5);
      chk("R7 no commit (rewind)", 32'(r_cv), 32'd0);
      chk("R7 no commit (drain)", 32'(d_cv), 32'd0);
      wb(4'd0, 32'h6);
      chk("R6 branch commits", r_cd, 32'h6);
      cyc();
      chk("R7 killed result dropped (rewind)", 32'(r_cv), 32'd0);
      chk("R7 killed result dropped (drain)", 32'(d_cv), 32'd0);
      chk("R8 tail after branch", 32'(r_itag), 32'd1);
      chk("R9 tail unchanged", 32'(d_itag), 32'd2);
   endtask

   task automatic t_kill_ins();
      do_reset();
      ins(16'hE0, 5'd1, 1'b1, 32'd0, 1'b1, 32'd0);
      ins_valid = 1'b1; ins_instr = 16'hE1;
      kill(4'd0);
      ins_valid = 1'b0;
      chk("R10 insert dropped (rewind)", 32'(r_itag), 32'd1);
      chk("R10 insert dropped (drain)", 32'(d_itag), 32'd1);
   endtask

   task automatic t_stray();
      do_reset();
      ins(16'h50, 5'd1, 1'b1, 32'd0, 1'b1, 32'd0);
      ins(16'h51, 5'd2, 1'b1, 32'd0, 1'b1, 32'd0);
      kill(4'd5);
      chk("R11 tail unchanged (rewind)", 32'(r_itag), 32'd2);
      chk("R11 tail unchanged (drain)", 32'(d_itag), 32'd2);
      take();
      chk("R11 younger survives", 32'(r_dtag), 32'd1);
      chk("R11 younger offered", 32'(r_dv), 32'd1);
   endtask

   initial begin
      t_reset();
      t_basic();
      t_wakeup();
      t_collide();
      t_oldest();
      t_full();
      t_order();
      t_kill();
      t_kill_wb();
      t_kill_ins();
      t_stray();
      if (!finished) begin
         finished = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule